// File: doc/BRIEF.md
# CRC-Checked Serial Register Write Receiver

This block sits behind the byte layer of a two-wire serial target. It receives bytes that have already been decoded, together with start and stop strobes, and turns them into writes to a local register space. A write reaches the register space only after a trailing CRC has been checked. If any CRC check fails, a sticky interrupt line is raised.

A frame opens with a control byte, followed by a high and a low address byte. The top bit of the high address byte selects the frame type. A single frame carries one data byte and then a CRC byte. A block frame carries a byte count, a header CRC, the data bytes and a payload CRC. Block data is held in a staging buffer. After a stop arrives behind a good payload CRC, the buffer is copied to the register space one byte per clock cycle.

Top module: `crcw_top`

## Requirements
- R1: A frame is accepted only when its first byte after start has 4'b1010 in bits 7:4 and 0 in bit 0. Any other first byte makes the block ignore every byte up to the next start, so the frame causes no write and no interrupt.
- R2: Bit 7 of the second byte selects the frame type: 0 means single, 1 means block. The write base address is the 15-bit value {second byte bits 6:0, third byte}, and block byte i goes to (base + i) modulo 2^15.
- R3: The CRC is CRC-8 with polynomial 0x07 and initial value 0x00. Each byte is processed MSB first, and there is no final inversion.
- R4: A single frame is control, high, low, data, CRC, with the CRC taken over those first four bytes. When the CRC matches, exactly one write of the data byte to the base address appears on the clock edge after the CRC byte is sampled.
- R5: A single frame whose CRC byte does not match produces no write and sets the interrupt.
- R6: A block frame is control, high, low, count n, header CRC, n data bytes, payload CRC, stop. The header CRC covers the high, low and count bytes only. The payload CRC restarts from zero and covers only the data bytes. When both match, the n bytes are written in order, one per cycle, starting on the edge after the stop is sampled.
- R7: A header CRC mismatch sets the interrupt. The rest of the frame is still consumed, and the frame writes nothing.
- R8: A payload CRC mismatch sets the interrupt and the frame writes nothing.
- R9: Any of the following cancels the frame with no write and no interrupt: a stop or a repeated start before the payload CRC, or any byte between the payload CRC and the stop. A repeated start also begins a new frame.
- R10: The interrupt stays set until the clear input is pulsed. A new mismatch in the same cycle as a clear leaves it set.
- R11: A block count above the buffer depth (32), or a count of zero, produces no write. The interrupt for such a frame depends only on its CRCs.
- R12: After reset the write strobe and the interrupt are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startStb | input | 1 | One-cycle start or repeated-start strobe |
| stopStb | input | 1 | One-cycle stop strobe |
| byteValid | input | 1 | A received byte is present on byteData |
| byteData | input | 8 | Received byte |
| irqClr | input | 1 | Clears the CRC interrupt |
| memWe | output | 1 | Register-space write strobe |
| memAddr | output | 15 | Register-space write address |
| memData | output | 8 | Register-space write data |
| crcIrq | output | 1 | Sticky CRC-error interrupt |

## Verification
The bench sweeps block lengths from 1 to 32 and runs single frames at many addresses, including a block that wraps past the top of the address space. A design that folded the control byte into the header CRC, or kept accumulating the CRC into the payload, would reject frames that are valid. A design that wrote data while it arrived would leak writes from frames that end with a header error, a payload error or a truncation. Out-of-range and zero counts, a first byte with a read flag or a wrong nibble, bytes after the payload CRC, and a repeated start in the middle of a block all go after commit gating that is too loose. Sticky checks on the interrupt catch a flag that clears itself.

// File: rtl/crcw_pkg.sv
package crcw_pkg;

  localparam int ADDR_W = 15;
  localparam logic [7:0] CRC_POLY = 8'h07;

  typedef struct packed {
    logic ldHi;
    logic ldLo;
    logic ldCnt;
    logic ldData;
    logic crcInit;   // restart both accumulators with the current byte in the full one
    logic crcStep;   // fold current byte into both accumulators
    logic payClr;    // restart the payload accumulator
    logic bufWr;
    logic idxClr;
    logic singleWr;
    logic drainClr;
    logic drainWr;
  } crcwStrobes_t;

  function automatic logic [7:0] crc8Step(input logic [7:0] crcIn, input logic [7:0] din);
    logic [7:0] c;
    logic fb;
    c = crcIn;
    for (int b = 7; b >= 0; b--) begin
      fb = c[7] ^ din[b];
      c  = {c[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
    end
    return c;
  endfunction

endpackage

// File: rtl/crcw_datapath.sv
module crcw_datapath
  import crcw_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  crcwStrobes_t      st,
  input  logic [7:0]        byteData,
  output logic [7:0]        crcFull,
  output logic [7:0]        crcPay,
  output logic              blkFlag,
  output logic              cntZero,
  output logic              cntOver,
  output logic              lastData,
  output logic              drainLast,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [7:0] DEPTH8 = 8'(DEPTH);

  logic [7:0] hiReg, loReg, cnt, dataReg, idx, drainIdx;
  logic [7:0] stage [DEPTH];
  logic [ADDR_W-1:0] baseAddr, offset;

  assign baseAddr  = {hiReg[6:0], loReg};
  assign offset    = st.drainWr ? ADDR_W'(drainIdx) : '0;
  assign blkFlag   = hiReg[7];
  assign cntZero   = (cnt == 8'd0);
  assign cntOver   = (cnt > DEPTH8);
  assign lastData  = (idx == cnt - 8'd1);
  assign drainLast = (drainIdx == cnt - 8'd1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiReg    <= '0;
      loReg    <= '0;
      cnt      <= '0;
      dataReg  <= '0;
      idx      <= '0;
      drainIdx <= '0;
      crcFull  <= '0;
      crcPay   <= '0;
      memWe    <= 1'b0;
      memAddr  <= '0;
      memData  <= '0;
    end else begin
      if (st.ldHi)   hiReg   <= byteData;
      if (st.ldLo)   loReg   <= byteData;
      if (st.ldCnt)  cnt     <= byteData;
      if (st.ldData) dataReg <= byteData;

      if (st.crcInit) begin
        crcFull <= crc8Step(8'h00, byteData);
        crcPay  <= 8'h00;
      end else if (st.payClr) begin
        crcPay  <= 8'h00;
      end else if (st.crcStep) begin
        crcFull <= crc8Step(crcFull, byteData);
        crcPay  <= crc8Step(crcPay, byteData);
      end

      if (st.idxClr)     idx <= '0;
      else if (st.bufWr) idx <= idx + 8'd1;

      if (st.drainClr)     drainIdx <= '0;
      else if (st.drainWr) drainIdx <= drainIdx + 8'd1;

      memWe <= st.singleWr | st.drainWr;
      if (st.singleWr | st.drainWr) begin
        memAddr <= baseAddr + offset;
        memData <= st.drainWr ? stage[drainIdx[IDX_W-1:0]] : dataReg;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (st.bufWr && idx < DEPTH8) stage[idx[IDX_W-1:0]] <= byteData;
  end

  // R11: staging writes never run past the buffer on an in-range count
  p_buf_bound_r11: assert property (@(posedge clk) disable iff (!rstN)
    (st.bufWr && !cntOver) |-> (idx < DEPTH8));

  // R6: drain never reads beyond the received count
  p_drain_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    st.drainWr |-> (drainIdx < cnt));

  // R6: drain walks consecutive addresses
  p_drain_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (st.drainWr && $past(st.drainWr)) |-> (drainIdx == $past(drainIdx) + 8'd1));

endmodule

// File: rtl/crcw_ctrl.sv
module crcw_ctrl
  import crcw_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startStb,
  input  logic         stopStb,
  input  logic         byteValid,
  input  logic [7:0]   byteData,
  input  logic         irqClr,
  input  logic [7:0]   crcFull,
  input  logic [7:0]   crcPay,
  input  logic         blkFlag,
  input  logic         cntZero,
  input  logic         cntOver,
  input  logic         lastData,
  input  logic         drainLast,
  output crcwStrobes_t st,
  output logic         crcIrq
);

  typedef enum logic [3:0] {
    S_IDLE, S_CTRL, S_HI, S_LO, S_SDAT, S_SCRC,
    S_BCNT, S_BHCRC, S_BDAT, S_BPCRC, S_BRDY, S_COMMIT
  } phase_e;

  phase_e state, nextState;
  logic hdrBad, setIrq, hdrFail;

  always_comb begin
    st        = '0;
    nextState = state;
    setIrq    = 1'b0;
    hdrFail   = 1'b0;
    if (state == S_COMMIT) begin
      st.drainWr = 1'b1;
      if (drainLast) nextState = S_IDLE;
    end else if (startStb) begin
      nextState = S_CTRL;
    end else if (stopStb) begin
      nextState = S_IDLE;
      if (state == S_BRDY && !cntZero) begin
        nextState   = S_COMMIT;
        st.drainClr = 1'b1;
      end
    end else if (byteValid) begin
      case (state)
        S_CTRL: begin
          if (byteData[7:4] == 4'hA && !byteData[0]) begin
            st.crcInit = 1'b1;
            nextState  = S_HI;
          end else begin
            nextState  = S_IDLE;
          end
        end
        S_HI: begin
          st.ldHi = 1'b1; st.crcStep = 1'b1; nextState = S_LO;
        end
        S_LO: begin
          st.ldLo = 1'b1; st.crcStep = 1'b1;
          nextState = blkFlag ? S_BCNT : S_SDAT;
        end
        S_SDAT: begin
          st.ldData = 1'b1; st.crcStep = 1'b1; nextState = S_SCRC;
        end
        S_SCRC: begin
          if (byteData == crcFull) st.singleWr = 1'b1;
          else                     setIrq      = 1'b1;
          nextState = S_IDLE;
        end
        S_BCNT: begin
          st.ldCnt = 1'b1; st.crcStep = 1'b1; nextState = S_BHCRC;
        end
        S_BHCRC: begin
          st.payClr = 1'b1; st.idxClr = 1'b1;
          hdrFail   = (byteData != crcPay);
          setIrq    = hdrFail;
          nextState = cntZero ? S_BPCRC : S_BDAT;
        end
        S_BDAT: begin
          st.bufWr = 1'b1; st.crcStep = 1'b1;
          if (lastData) nextState = S_BPCRC;
        end
        S_BPCRC: begin
          if (byteData != crcPay) begin
            setIrq    = 1'b1;
            nextState = S_IDLE;
          end else begin
            nextState = (hdrBad || cntOver) ? S_IDLE : S_BRDY;
          end
        end
        S_BRDY:  nextState = S_IDLE;
        default: nextState = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      hdrBad <= 1'b0;
      crcIrq <= 1'b0;
    end else begin
      state <= nextState;
      if (st.crcInit)    hdrBad <= 1'b0;
      else if (hdrFail)  hdrBad <= 1'b1;
      if (setIrq)        crcIrq <= 1'b1;
      else if (irqClr)   crcIrq <= 1'b0;
    end
  end

  // R10: interrupt holds until cleared
  p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (crcIrq && !irqClr) |=> crcIrq);

  // R6: a drain only begins on a stop
  p_commit_on_stop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_COMMIT && $past(state) != S_COMMIT) |-> $past(stopStb));

  // R7: a frame with a failed header never drains
  p_no_commit_hdrbad_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_COMMIT) |-> !hdrBad);

  // R5: a mismatching single CRC never raises a write strobe
  p_single_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    st.singleWr |-> !setIrq);

endmodule

// File: rtl/crcw_top.sv
module crcw_top
  import crcw_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStb,
  input  logic              stopStb,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  input  logic              irqClr,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData,
  output logic              crcIrq
);

  crcwStrobes_t st;
  logic [7:0] crcFull, crcPay;
  logic blkFlag, cntZero, cntOver, lastData, drainLast;

  crcw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startStb(startStb), .stopStb(stopStb),
    .byteValid(byteValid), .byteData(byteData), .irqClr(irqClr),
    .crcFull(crcFull), .crcPay(crcPay), .blkFlag(blkFlag),
    .cntZero(cntZero), .cntOver(cntOver), .lastData(lastData),
    .drainLast(drainLast), .st(st), .crcIrq(crcIrq)
  );

  crcw_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .byteData(byteData),
    .crcFull(crcFull), .crcPay(crcPay), .blkFlag(blkFlag),
    .cntZero(cntZero), .cntOver(cntOver), .lastData(lastData),
    .drainLast(drainLast), .memWe(memWe), .memAddr(memAddr), .memData(memData)
  );

endmodule

// File: tb/tb_crcw_top.sv
module tb_crcw_top;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startStb = 1'b0, stopStb = 1'b0, byteValid = 1'b0, irqClr = 1'b0;
  logic [7:0] byteData = '0;
  logic memWe, crcIrq;
  logic [14:0] memAddr;
  logic [7:0] memData;

  int nChk = 0, nFail = 0, wrN = 0;
  logic [14:0] wrA [64];
  logic [7:0]  wrD [64];
  logic [7:0]  blk [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  crcw_top dut (
    .clk(clk), .rstN(rstN), .startStb(startStb), .stopStb(stopStb),
    .byteValid(byteValid), .byteData(byteData), .irqClr(irqClr),
    .memWe(memWe), .memAddr(memAddr), .memData(memData), .crcIrq(crcIrq)
  );

  always @(negedge clk) begin
    if (rstN && memWe) begin
      if (wrN < 64) begin
        wrA[wrN] = memAddr;
        wrD[wrN] = memData;
      end
      wrN = wrN + 1;
    end
  end

  function automatic logic [7:0] crcRef(input logic [7:0] c0, input logic [7:0] d);
    logic [7:0] c = c0;
    for (int i = 0; i < 8; i++) begin
      if (c[7] ^ d[7-i]) c = (c << 1) ^ 8'h07;
      else               c = c << 1;
    end
    return c;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    byteData = b; byteValid = 1'b1;
    @(negedge clk);
    byteValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic pStart;
    startStb = 1'b1; @(negedge clk); startStb = 1'b0; @(negedge clk);
  endtask

  task automatic pStop;
    stopStb = 1'b1; @(negedge clk); stopStb = 1'b0; @(negedge clk);
  endtask

  task automatic settle;
    repeat (40) @(negedge clk);
  endtask

  task automatic clearIrq;
    irqClr = 1'b1; @(negedge clk); irqClr = 1'b0; @(negedge clk);
  endtask

  task automatic sendSingle(input logic [7:0] ctl, input logic [7:0] hi, input logic [7:0] lo,
                            input logic [7:0] d, input bit good);
    logic [7:0] c;
    c = crcRef(crcRef(crcRef(crcRef(8'h00, ctl), hi), lo), d);
    if (!good) c = c ^ 8'h01;
    wrN = 0;
    pStart; sendByte(ctl); sendByte(hi); sendByte(lo); sendByte(d); sendByte(c); pStop;
    settle;
  endtask

  // cut: number of data bytes sent before an early stop (-1 = full frame)
  task automatic sendBlock(input logic [7:0] hi, input logic [7:0] lo, input int n, input int seed,
                           input bit hdrGood, input bit payGood, input int cut, input bit extra);
    logic [7:0] hc, pc;
    hi[7] = 1'b1;
    hc = crcRef(crcRef(crcRef(8'h00, hi), lo), 8'(n));
    if (!hdrGood) hc = hc ^ 8'h80;
    pc = 8'h00;
    for (int i = 0; i < n; i++) begin
      blk[i % 64] = 8'((seed + i * 37) & 255);
      pc = crcRef(pc, 8'((seed + i * 37) & 255));
    end
    if (!payGood) pc = pc ^ 8'h10;
    wrN = 0;
    pStart; sendByte(8'hA0); sendByte(hi); sendByte(lo); sendByte(8'(n)); sendByte(hc);
    for (int i = 0; i < n; i++) begin
      if (cut >= 0 && i == cut) break;
      sendByte(8'((seed + i * 37) & 255));
    end
    if (cut < 0) begin
      sendByte(pc);
      if (extra) sendByte(8'h5A);
    end
    pStop;
    settle;
  endtask

  task automatic checkBlockWrites(input string req, input logic [14:0] base, input int n);
    int bad = 0;
    chk({req, " write count"}, wrN, n);
    for (int i = 0; i < n && i < 64; i++) begin
      if (wrA[i] != 15'(base + 15'(i)) || wrD[i] != blk[i]) bad++;
    end
    chk({req, " address/data mismatches"}, bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 memWe at reset", int'(memWe), 0);
    chk("R12 crcIrq at reset", int'(crcIrq), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R4 R2 R3: single frames over many addresses and data values
    for (int i = 0; i < 12; i++) begin
      logic [7:0] hi, lo, d;
      hi = 8'((i * 17) & 127); lo = 8'((i * 53 + 7) & 255); d = 8'((i * 29 + 3) & 255);
      sendSingle(8'hA0 | 8'((i & 7) << 1), hi, lo, d, 1'b1);
      chk("R4 single write count", wrN, 1);
      chk("R2 single address", int'(wrA[0]), int'({hi[6:0], lo}));
      chk("R3 single data", int'(wrD[0]), int'(d));
    end
    chk("R4 no irq on good singles", int'(crcIrq), 0);

    // R5 bad single CRC, then R10 stickiness and clear
    sendSingle(8'hA0, 8'h12, 8'h34, 8'h56, 1'b0);
    chk("R5 bad single no write", wrN, 0);
    chk("R5 bad single irq", int'(crcIrq), 1);
    sendSingle(8'hA0, 8'h01, 8'h02, 8'h03, 1'b1);
    chk("R10 irq sticky across good frame", int'(crcIrq), 1);
    chk("R10 good frame still writes", wrN, 1);
    clearIrq;
    chk("R10 irq cleared", int'(crcIrq), 0);

    // R1 rejected first bytes
    sendSingle(8'hB0, 8'h10, 8'h20, 8'h30, 1'b1);
    chk("R1 wrong nibble ignored", wrN, 0);
    sendSingle(8'hA1, 8'h10, 8'h20, 8'h30, 1'b1);
    chk("R1 read flag ignored", wrN, 0);
    sendSingle(8'h50, 8'h10, 8'h20, 8'h30, 1'b0);
    chk("R1 ignored frame raises no irq", int'(crcIrq), 0);

    // R6 R2 block sweep over every length
    for (int n = 1; n <= 32; n++) begin
      sendBlock(8'((n * 11) & 127), 8'((n * 19) & 255), n, n * 7, 1'b1, 1'b1, -1, 1'b0);
      checkBlockWrites("R6 block", {7'((n * 11) & 127), 8'((n * 19) & 255)}, n);
    end
    chk("R6 no irq on good blocks", int'(crcIrq), 0);
    sendBlock(8'h7F, 8'hF0, 32, 200, 1'b1, 1'b1, -1, 1'b0);
    checkBlockWrites("R2 block wrap", 15'h7FF0, 32);

    // R7 header error
    sendBlock(8'h05, 8'h06, 4, 9, 1'b0, 1'b1, -1, 1'b0);
    chk("R7 header error no write", wrN, 0);
    chk("R7 header error irq", int'(crcIrq), 1);
    clearIrq;

    // R8 payload error
    sendBlock(8'h05, 8'h06, 6, 9, 1'b1, 1'b0, -1, 1'b0);
    chk("R8 payload error no write", wrN, 0);
    chk("R8 payload error irq", int'(crcIrq), 1);
    clearIrq;

    // R9 truncations and trailing byte
    sendBlock(8'h05, 8'h06, 4, 1, 1'b1, 1'b1, 2, 1'b0);
    chk("R9 early stop no write", wrN, 0);
    chk("R9 early stop no irq", int'(crcIrq), 0);
    sendBlock(8'h05, 8'h06, 4, 1, 1'b1, 1'b1, -1, 1'b1);
    chk("R9 extra byte cancels", wrN, 0);
    begin
      logic [7:0] c;
      wrN = 0;
      pStart; sendByte(8'hA0); sendByte(8'h83); sendByte(8'h44); sendByte(8'd4);
      sendByte(crcRef(crcRef(crcRef(8'h00, 8'h83), 8'h44), 8'd4)); sendByte(8'h99);
      c = crcRef(crcRef(crcRef(crcRef(8'h00, 8'hA0), 8'h02), 8'h22), 8'h77);
      pStart; sendByte(8'hA0); sendByte(8'h02); sendByte(8'h22); sendByte(8'h77); sendByte(c); pStop;
      settle;
      chk("R9 restart: only new frame writes", wrN, 1);
      chk("R9 restart: new frame address", int'(wrA[0]), int'(15'h0222));
      chk("R9 restart: no irq", int'(crcIrq), 0);
    end

    // R11 out-of-range and zero counts
    sendBlock(8'h05, 8'h06, 33, 3, 1'b1, 1'b1, -1, 1'b0);
    chk("R11 count above depth no write", wrN, 0);
    chk("R11 count above depth no irq", int'(crcIrq), 0);
    sendBlock(8'h05, 8'h06, 0, 3, 1'b1, 1'b1, -1, 1'b0);
    chk("R11 zero count no write", wrN, 0);
    chk("R11 zero count no irq", int'(crcIrq), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", nChk, nFail);
    $finish;
  end

endmodule